// File: doc/BRIEF.md
# Statistical Operation Sample Selector

This block watches a stream of dispatched operations, one per cycle at most, and marks single operations for profiling. A down-counter that moves only on cycles where an operation is presented counts off a programmable interval; the operation on which it expires gets a one-cycle tag. When jitter is turned on, a pseudo-random amount is added to every reload, so the sampling points do not lock onto loops whose period matches the interval.

Only one tagged operation may be outstanding. The tag raises a busy flag that the downstream collector lowers with a completion strobe. If the counter expires while the flag is still up, the new sample is discarded and a saturating collision counter goes up by one. The count is taken before any filtering further down, so it includes samples that a filter would later have thrown away. Writing the configuration restarts the interval count and reseeds the random source, so a given setting always produces the same sequence of sample points.

Top module: `op_sample_sel`

## Requirements
- R1: The counter moves only on cycles with `op_valid` high. After a load of length N, the N-th valid operation has `sample_tag` high in the same cycle (combinational), provided it is accepted.
- R2: A programmed interval below the `MIN_INTERVAL` parameter (default 2), zero included, acts as `MIN_INTERVAL`. After reset the block behaves as if the interval were zero and jitter were off.
- R3: With jitter on, every reload length is the effective interval plus bits [7:0] of a 16-bit LFSR. The LFSR steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]} once per expiry, after its value has been used. A configuration write loads the counter with interval + seed[7:0] and sets the LFSR to step(seed). A seed of zero is replaced by 16'hACE1.
- R4: `sample_tag` is never high while `busy` is high, unless `op_done` is high in the same cycle.
- R5: `busy` sets in the cycle after an accepted sample and clears in the cycle after `op_done`. When completion and an expiry fall in the same cycle, completion is applied first: the sample is accepted and `busy` stays high.
- R6: An expiry while `busy` is high and `op_done` is low gives no tag, and `collisions` rises by one in the next cycle.
- R7: The counter reloads on every expiry, whether the sample is accepted or dropped.
- R8: `collisions` (COLL_W bits, default 32) saturates at its all-ones value and never wraps.
- R9: A cycle with `cfg_wr` high reloads the counter and the LFSR from the new configuration. The operation presented in that cycle is neither counted nor tagged. `busy` and `collisions` are left unchanged.
- R10: During and after reset, `busy` is 0, `collisions` is 0 and no tag is raised until an interval has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is dispatched this cycle |
| op_done | input | 1 | The tagged operation has completed |
| cfg_wr | input | 1 | Write strobe for the configuration fields below |
| cfg_interval | input | 16 | Sampling interval in operations |
| cfg_jitter_en | input | 1 | Add LFSR perturbation to each reload |
| cfg_seed | input | 16 | LFSR seed, loaded on `cfg_wr` |
| sample_tag | output | 1 | The current operation is selected for sampling |
| busy | output | 1 | A sampled operation is in flight |
| collisions | output | COLL_W | Saturating count of dropped samples |

## Verification
Two events can fall in the same cycle: a counter expiry and the completion strobe of the previous sample. The bench provokes this by raising `op_done` exactly on an expiring operation. The expected result is a tag, `busy` still high afterwards and no change to the collision count. The opposite case, where the expiry arrives without completion, must drop the sample and raise the count. A configuration write on the same cycle as a valid operation is also tested: at that point the counter sits one step from expiry, so if the write did not take priority, a tag would appear.

// File: rtl/op_samp_pkg.sv
`timescale 1ns/1ps
package op_samp_pkg;

    localparam int IVAL_W = 16;
    localparam int LFSR_W = 16;
    localparam int JIT_W  = 8;
    localparam int CNT_W  = IVAL_W + 1;
    localparam logic [LFSR_W-1:0] LFSR_SUBST = 16'hACE1;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_TAKE = 2'd1,
        PICK_DROP = 2'd2
    } pick_e;

    typedef struct packed {
        logic [IVAL_W-1:0] ival;
        logic              jit;
    } samp_cfg_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
        return (s == '0) ? LFSR_SUBST : s;
    endfunction

    function automatic logic [CNT_W-1:0] reload_len(
        input logic [IVAL_W-1:0] ival,
        input logic [IVAL_W-1:0] min_ival,
        input logic              jit,
        input logic [LFSR_W-1:0] rnd
    );
        logic [IVAL_W-1:0] eff;
        eff = (ival < min_ival) ? min_ival : ival;
        return {1'b0, eff} + (jit ? CNT_W'(rnd[JIT_W-1:0]) : '0);
    endfunction

endpackage

// File: rtl/samp_lfsr.sv
`timescale 1ns/1ps
module samp_lfsr
    import op_samp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              adv,
    output logic [LFSR_W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst)
            state <= LFSR_SUBST;
        else if (load)
            state <= lfsr_step(seed_fix(seed));
        else if (adv)
            state <= lfsr_step(state);
    end

    // LFSR must never lock up in the all-zero state (R3)
    p_lfsr_live_r3: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/samp_interval_ctr.sv
`timescale 1ns/1ps
module samp_interval_ctr
    import op_samp_pkg::*;
#(
    parameter logic [CNT_W-1:0] RESET_LEN = CNT_W'(2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    assign expire = op_valid && !load && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= RESET_LEN;
        else if (load || expire)
            cnt <= reload_val;
        else if (op_valid)
            cnt <= cnt - CNT_W'(1);
    end

    // Counter never idles at zero (R1)
    p_cnt_live_r1: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);

    // No operation and no write: count holds (R1)
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !load) |=> $stable(cnt));

    // Every expiry leads to a full reload (R7)
    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt != '0) && (cnt >= CNT_W'(1)) && (cnt == $past(reload_val)));

endmodule

// File: rtl/samp_inflight.sv
`timescale 1ns/1ps
module samp_inflight
    import op_samp_pkg::*;
#(
    parameter int COLL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              expire,
    input  logic              done,
    output pick_e             pick,
    output logic              busy,
    output logic [COLL_W-1:0] coll
);

    localparam logic [COLL_W-1:0] COLL_MAX = '1;

    always_comb begin
        pick = PICK_NONE;
        if (expire)
            pick = (!busy || done) ? PICK_TAKE : PICK_DROP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            coll <= '0;
        end else begin
            busy <= (busy && !done) || (pick == PICK_TAKE);
            if (pick == PICK_DROP && coll != COLL_MAX)
                coll <= coll + COLL_W'(1);
        end
    end

    // Completion without a new expiry frees the slot (R5)
    p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !expire) |=> !busy);

    // Completion and expiry together: the new sample is taken (R5)
    p_coincide_r5: assert property (@(posedge clk) disable iff (rst)
        (done && expire) |=> busy);

    // Busy without completion stays busy (R4)
    p_hold_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // Drop increments the count unless saturated (R6)
    p_coll_step_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && busy && !done && coll != COLL_MAX) |=> coll == $past(coll) + COLL_W'(1));

    // Nothing but a drop touches the count (R6)
    p_coll_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !(expire && busy && !done) |=> $stable(coll));

    // Saturation holds (R8)
    p_coll_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (coll == COLL_MAX) |=> (coll == COLL_MAX));

endmodule

// File: rtl/op_sample_sel.sv
`timescale 1ns/1ps
module op_sample_sel
    import op_samp_pkg::*;
#(
    parameter int MIN_INTERVAL = 2,
    parameter int COLL_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_done,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_interval,
    input  logic              cfg_jitter_en,
    input  logic [15:0]       cfg_seed,
    output logic              sample_tag,
    output logic              busy,
    output logic [COLL_W-1:0] collisions
);

    localparam logic [IVAL_W-1:0] MIN_V =
        (MIN_INTERVAL < 1) ? IVAL_W'(1) : IVAL_W'(MIN_INTERVAL);
    localparam logic [CNT_W-1:0] RESET_LEN = {1'b0, MIN_V};

    samp_cfg_t         cfg_q;
    logic [LFSR_W-1:0] lfsr_q;
    logic [CNT_W-1:0]  reload;
    logic              expire;
    pick_e             pick;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '{ival: '0, jit: 1'b0};
        else if (cfg_wr)
            cfg_q <= '{ival: cfg_interval, jit: cfg_jitter_en};
    end

    always_comb begin
        if (cfg_wr)
            reload = reload_len(cfg_interval, MIN_V, cfg_jitter_en, seed_fix(cfg_seed));
        else
            reload = reload_len(cfg_q.ival, MIN_V, cfg_q.jit, lfsr_q);
    end

    samp_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_wr),
        .seed  (cfg_seed),
        .adv   (expire),
        .state (lfsr_q)
    );

    samp_interval_ctr #(.RESET_LEN(RESET_LEN)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .load       (cfg_wr),
        .reload_val (reload),
        .expire     (expire)
    );

    samp_inflight #(.COLL_W(COLL_W)) u_slot (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .done   (op_done),
        .pick   (pick),
        .busy   (busy),
        .coll   (collisions)
    );

    assign sample_tag = (pick == PICK_TAKE);

    // Single sample in flight (R4)
    p_single_r4: assert property (@(posedge clk) disable iff (rst)
        sample_tag |-> (!busy || op_done));

    // Only a real operation can be tagged (R1)
    p_tag_valid_r1: assert property (@(posedge clk) disable iff (rst)
        sample_tag |-> op_valid);

    // A configuration write never tags (R9)
    p_wr_notag_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |-> !sample_tag);

    // An accepted sample leaves the slot occupied (R5)
    p_tag_busy_r5: assert property (@(posedge clk) disable iff (rst)
        sample_tag |=> busy);

endmodule

// File: tb/op_sample_sel_tb.sv
`timescale 1ns/1ps
module op_sample_sel_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0, op_done = 1'b0, cfg_wr = 1'b0, cfg_jitter_en = 1'b0;
    logic [15:0] cfg_interval = '0, cfg_seed = '0;
    logic        sample_tag, busy;
    logic [31:0] collisions;
    logic        s_valid = 1'b0;
    logic        s_tag, s_busy;
    logic [2:0]  s_coll;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    op_sample_sel u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_done(op_done),
        .cfg_wr(cfg_wr), .cfg_interval(cfg_interval), .cfg_jitter_en(cfg_jitter_en),
        .cfg_seed(cfg_seed), .sample_tag(sample_tag), .busy(busy), .collisions(collisions)
    );

    op_sample_sel #(.MIN_INTERVAL(2), .COLL_W(3)) u_sat (
        .clk(clk), .rst(rst), .op_valid(s_valid), .op_done(1'b0),
        .cfg_wr(1'b0), .cfg_interval(16'd0), .cfg_jitter_en(1'b0),
        .cfg_seed(16'd0), .sample_tag(s_tag), .busy(s_busy), .collisions(s_coll)
    );

    // row: {wr, interval[15:0], valid, done, exp_tag, exp_busy, exp_coll[7:0]}
    localparam int NV = 24;
    localparam logic [28:0] VT [NV] = '{
        {1'b1, 16'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},  // R9 load 3
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0},  // R1
        {1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},  // R1 idle: no count
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0},  // R1 third valid op tagged
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1},  // R6 collision
        {1'b0, 16'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1},  // R5 completion
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},  // R7 reload after drop
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1},
        {1'b0, 16'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd1},  // R5 done + expiry together
        {1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1},
        {1'b1, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R2 zero -> minimum
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},  // R2 tag after 2
        {1'b0, 16'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1},  // counter now at 1
        {1'b1, 16'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},  // R9 op on write ignored; R2 1 -> 2
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1},
        {1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd2}   // R6 second drop
    };

    function automatic logic [15:0] model_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [15:0] iv, input logic jit,
                       input logic [15:0] sd, input logic v, input logic d,
                       output logic tag);
        @(negedge clk);
        cfg_wr = wr; cfg_interval = iv; cfg_jitter_en = jit; cfg_seed = sd;
        op_valid = v; op_done = d;
        #1 tag = sample_tag;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_wr = 0; op_valid = 0; op_done = 0; s_valid = 0;
        @(posedge clk); @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic t;
        logic [15:0] l;
        int n, found, expg;

        // R10 reset state
        do_reset();
        #2;
        check("R10 busy after reset", busy, 0);
        check("R10 collisions after reset", collisions, 0);
        check("R10 no tag after reset", sample_tag, 0);

        // R2 default interval is the minimum
        cyc(0, 0, 0, 0, 1, 0, t);
        check("R2 first op untagged", t, 0);
        cyc(0, 0, 0, 0, 1, 0, t);
        check("R2 second op tagged", t, 1);

        // Vector table
        do_reset();
        for (int i = 0; i < NV; i++) begin
            logic [28:0] r;
            r = VT[i];
            cyc(r[28], r[27:12], 1'b0, 16'd0, r[11], r[10], t);
            check($sformatf("R1 R4 tag row %0d", i), t, r[9]);
            check($sformatf("R5 busy row %0d", i), busy, r[8]);
            check($sformatf("R6 collisions row %0d", i), collisions, r[7:0]);
        end

        // R3 jitter gaps follow the LFSR
        do_reset();
        cyc(1, 16'd3, 1, 16'h00A5, 0, 1, t);
        l = model_step(16'h00A5);
        expg = 3 + 16'hA5; n = 0; found = 0;
        for (int c = 0; c < 3000 && found < 3; c++) begin
            cyc(0, 0, 0, 0, 1, 1, t);
            n++;
            if (t) begin
                check("R3 jitter gap", n, expg);
                expg = 3 + int'(l[7:0]);
                l = model_step(l);
                n = 0; found++;
            end
        end
        check("R3 jittered tags seen", found, 3);

        // R9 rewrite restarts counter and LFSR
        for (int c = 0; c < 10; c++) cyc(0, 0, 0, 0, 1, 1, t);
        cyc(1, 16'd3, 1, 16'h00A5, 1, 1, t);
        check("R9 no tag on write", t, 0);
        n = 0; found = 0;
        for (int c = 0; c < 400 && found == 0; c++) begin
            cyc(0, 0, 0, 0, 1, 1, t);
            n++;
            if (t) found = 1;
        end
        check("R9 gap after rewrite", n, 3 + 16'hA5);

        // R3 zero seed replaced
        cyc(1, 16'd3, 1, 16'h0000, 0, 1, t);
        n = 0; found = 0;
        for (int c = 0; c < 400 && found == 0; c++) begin
            cyc(0, 0, 0, 0, 1, 1, t);
            n++;
            if (t) found = 1;
        end
        check("R3 zero seed gap", n, 3 + 16'hE1);

        // R8 saturation on a narrow counter
        do_reset();
        @(negedge clk); s_valid = 1'b1;
        for (int c = 0; c < 10; c++) @(negedge clk);
        check("R8 count before saturation", s_coll, 4);
        for (int c = 0; c < 20; c++) @(negedge clk);
        check("R8 saturated count", s_coll, 7);
        check("R8 busy held", s_busy, 1);
        s_valid = 1'b0;

        finished = 1;
        finish_run();
    end

endmodule